// File: doc/BRIEF.md
# Stopped-Clock Watchdog

This block monitors a system clock from a separate, free-running reference clock and raises a reset request when the monitored clock stops toggling. The monitored clock is treated as a plain data signal. It is brought into the reference domain through a two-stage synchronizer. Every change between successive synchronized samples restarts a timeout counter. When the counter runs a full window without seeing a change, the block asserts its request. It does not check frequency. It only detects a clock that is frozen at either level.

The window length is a parameter counted in reference cycles. It is the supervision interval divided by the reference period, so 100 µs at a 10 MHz reference gives 1000 cycles. An enable input gates the whole function. A sticky cause flag records that a timeout has occurred, so that the reason for the reset can be read after the request has gone away.

Top module: `clk_loss_monitor`

## Requirements
- R1: With `det_enable` high, `reset_req` rises `TIMEOUT_CYCLES` reference cycles after the synchronized level last changed. The change is seen 2 cycles after the toggle, and the counter is cleared 3 rising edges after the toggle. So, counting rising edges after the toggle, `reset_req` is 0 at edges 3 to `TIMEOUT_CYCLES`+2 and 1 from edge `TIMEOUT_CYCLES`+3 onward.
- R2: Any change of the synchronized monitored level restarts the window and drops `reset_req` by the 3rd rising edge after the toggle.
- R3: While `det_enable` is low, `reset_req` is 0 from the next rising edge onward, and the counter is held at zero.
- R4: Enabling restarts the window. With the monitored clock frozen, `det_enable` sampled high after being low gives `reset_req` = 0 for `TIMEOUT_CYCLES` edges and 1 from edge `TIMEOUT_CYCLES`+1 onward.
- R5: Once raised, `reset_req` stays high until the monitored clock toggles or the detector is disabled.
- R6: `clk_lost_cause` goes to 1 on the edge after `reset_req` is 1. It stays 1 until `ref_rst_n` is asserted, even after the request clears.
- R7: While `ref_rst_n` is low, `reset_req` and `clk_lost_cause` are 0.
- R8: A monitored clock frozen high and one frozen low are both detected, with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| ref_rst_n | input | 1 | Active-low asynchronous reset, reference domain |
| mon_clk | input | 1 | Monitored clock, sampled as data |
| det_enable | input | 1 | Detector enable, synchronous to ref_clk |
| reset_req | output | 1 | Timeout reset request |
| clk_lost_cause | output | 1 | Sticky flag: a timeout has occurred |

## Verification
The assertions check the following on every cycle:
- The request is never raised while the detector is off, or on the edge after it is turned off.
- A synchronized level change always drops the request.
- The request never rises before a full quiet window has elapsed.
- The cause flag follows the request and never falls outside reset.

The exact cycle on which the request rises after a toggle or after enabling, and the behaviour with both frozen levels, can only be shown by the bench's scenarios. The same holds for the request persisting and the cause flag surviving until reset. The bench measures these against the latency arithmetic in R1 and R4.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

    // Synchronizer and edge-history state for the monitored level
    typedef struct packed {
        logic meta;   // first capture stage
        logic level;  // second capture stage, safe to use
        logic last;   // previous safe sample
    } mcd_sync_t;

    // Sticky cause state
    typedef struct packed {
        logic seen;
    } mcd_cause_t;

endpackage

// File: rtl/mcd_level_sync.sv
module mcd_level_sync
    import mcd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level_change
);

    mcd_sync_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.meta  = async_in;
        st_d.level = st_q.meta;
        st_d.last  = st_q.level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_change = st_q.level ^ st_q.last;

endmodule

// File: rtl/mcd_stall_timer.sv
module mcd_stall_timer #(
    parameter int unsigned TIMEOUT_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic restart,
    output logic expired
);

    localparam int unsigned CW = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          en_prev;
        logic          hit;
    } timer_t;

    timer_t t_d, t_q;

    always_comb begin
        t_d         = t_q;
        t_d.en_prev = enable;
        if (!enable || restart || !t_q.en_prev) begin
            // disabled, level changed, or enable just rose: restart window
            t_d.cnt = '0;
            t_d.hit = 1'b0;
        end else begin
            if (t_q.cnt != LIMIT) t_d.cnt = t_q.cnt + 1'b1;
            t_d.hit = (t_d.cnt == LIMIT);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign expired = t_q.hit;

endmodule

// File: rtl/mcd_cause_latch.sv
module mcd_cause_latch
    import mcd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    output logic flag
);

    mcd_cause_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.seen = c_q.seen | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign flag = c_q.seen;

endmodule

// File: rtl/clk_loss_monitor.sv
module clk_loss_monitor #(
    parameter int unsigned TIMEOUT_CYCLES = 1000
) (
    input  logic ref_clk,
    input  logic ref_rst_n,
    input  logic mon_clk,
    input  logic det_enable,
    output logic reset_req,
    output logic clk_lost_cause
);

    logic level_change;

    mcd_level_sync u_sync (
        .clk          (ref_clk),
        .rst_n        (ref_rst_n),
        .async_in     (mon_clk),
        .level_change (level_change)
    );

    mcd_stall_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
        .clk     (ref_clk),
        .rst_n   (ref_rst_n),
        .enable  (det_enable),
        .restart (level_change),
        .expired (reset_req)
    );

    mcd_cause_latch u_cause (
        .clk   (ref_clk),
        .rst_n (ref_rst_n),
        .set   (reset_req),
        .flag  (clk_lost_cause)
    );

endmodule

// File: rtl/clk_loss_monitor_chk.sv
module clk_loss_monitor_chk #(
    parameter int unsigned TIMEOUT_CYCLES = 1000
) (
    input logic ref_clk,
    input logic ref_rst_n,
    input logic det_enable,
    input logic level_change,
    input logic reset_req,
    input logic clk_lost_cause
);

    localparam int unsigned QW = $clog2(TIMEOUT_CYCLES + 2);

    logic [QW-1:0] quiet_q;
    logic          en_q;

    // Independent count of quiet, enabled cycles since the last restart
    always_ff @(posedge ref_clk or negedge ref_rst_n) begin
        if (!ref_rst_n) begin
            quiet_q <= '0;
            en_q    <= 1'b0;
        end else begin
            en_q <= det_enable;
            if (!det_enable || level_change || !en_q) quiet_q <= '0;
            else if (quiet_q < QW'(TIMEOUT_CYCLES + 1)) quiet_q <= quiet_q + 1'b1;
        end
    end

    p_no_early_r1: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        reset_req |-> (quiet_q >= QW'(TIMEOUT_CYCLES)));

    p_change_drops_r2: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        level_change |=> !reset_req);

    p_off_quiet_r3: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        !det_enable |=> !reset_req);

    p_rise_when_on_r5: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        (reset_req && det_enable && !level_change) |=> reset_req);

    p_cause_follows_r6: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        reset_req |=> clk_lost_cause);

    p_cause_sticky_r6: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        clk_lost_cause |=> clk_lost_cause);

endmodule

bind clk_loss_monitor clk_loss_monitor_chk #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_chk (
    .ref_clk        (ref_clk),
    .ref_rst_n      (ref_rst_n),
    .det_enable     (det_enable),
    .level_change   (level_change),
    .reset_req      (reset_req),
    .clk_lost_cause (clk_lost_cause)
);

// File: tb/clk_loss_monitor_bench.sv
module clk_loss_monitor_bench;

    localparam int L = 40;

    logic ref_clk = 1'b0;
    logic ref_rst_n = 1'b0;
    logic mon_clk = 1'b0;
    logic det_enable = 1'b0;
    logic reset_req;
    logic clk_lost_cause;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 ref_clk = ~ref_clk;

    clk_loss_monitor #(.TIMEOUT_CYCLES(L)) u_clk_loss_monitor (
        .ref_clk        (ref_clk),
        .ref_rst_n      (ref_rst_n),
        .mon_clk        (mon_clk),
        .det_enable     (det_enable),
        .reset_req      (reset_req),
        .clk_lost_cause (clk_lost_cause)
    );

    function automatic logic exp_after_toggle(int n);
        return (n >= L + 3);
    endfunction

    function automatic logic exp_after_enable(int n);
        return (n >= L + 1);
    endfunction

    task automatic check(string req, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // toggle monitored clock, then follow the window for n edges
    task automatic stall(int n, string req);
        mon_clk = ~mon_clk;
        for (int k = 1; k <= n; k++) begin
            @(negedge ref_clk);
            if (k >= 3) check(req, reset_req, exp_after_toggle(k));
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));

        // R7: reset state
        repeat (3) @(negedge ref_clk);
        check("R7", reset_req, 1'b0);
        check("R7", clk_lost_cause, 1'b0);
        ref_rst_n = 1'b1;
        det_enable = 1'b1;
        repeat (4) @(negedge ref_clk);

        // R1 / R8: frozen high, then frozen low, exact boundary
        stall(L + 6, "R1 R8 high");        // toggled 0->1
        check("R6", clk_lost_cause, 1'b1);
        stall(L + 6, "R1 R8 low");         // toggled 1->0

        // R5: request persists while frozen
        repeat (50) @(negedge ref_clk);
        check("R5", reset_req, 1'b1);

        // R2: short gaps never time out
        for (int i = 0; i < 5; i++) stall(L, "R2");
        check("R6 sticky", clk_lost_cause, 1'b1);

        // R3: disable drops request and keeps it low
        stall(L + 5, "R1");
        det_enable = 1'b0;
        @(negedge ref_clk);
        check("R3", reset_req, 1'b0);
        repeat (2 * L) @(negedge ref_clk);
        check("R3", reset_req, 1'b0);

        // R4: enabling restarts the window with clock frozen
        det_enable = 1'b1;
        for (int k = 1; k <= L + 4; k++) begin
            @(negedge ref_clk);
            check("R4", reset_req, exp_after_enable(k));
        end

        // R5: toggle while requesting clears it (R2)
        stall(5, "R2 R5");

        // Random gaps
        for (int i = 0; i < 30; i++) begin
            int gap;
            gap = $urandom_range(3, 2 * L);
            stall(gap, "R1 R2 random");
        end

        // R7: reset clears the cause flag
        ref_rst_n = 1'b0;
        @(negedge ref_clk);
        check("R7", clk_lost_cause, 1'b0);
        check("R7", reset_req, 1'b0);
        ref_rst_n = 1'b1;
        repeat (3) @(negedge ref_clk);
        stall(L + 2, "R1");
        check("R6", clk_lost_cause, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule